// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Unit

This block sits between seven active-low interrupt request lines and a processor core. It watches the lines and compares them with the 3-bit interrupt mask that the core keeps in its status register. When a request should interrupt the core, the block presents a valid flag and the encoded level. It also presents the mask value that the core loads when it accepts that request. The presented level stays put until the core pulses its take-interrupt handshake. Stacking, vector fetch and the acknowledge bus cycle are handled elsewhere.

Lines 1 to 6 are sampled as levels. Each is gated by the mask, and a line that is still low when the mask is lowered again is recognized again at once. Line 7 cannot be masked. A recognition latch tracks it, and that latch arms on a falling edge. The latch disarms on a rising edge of the line or on any status-register write. A return from exception restores the status register, so the latch disarms then as well. A line 7 that is still low after such a write therefore raises a fresh request with no pin transition. Every line passes through a synchronizer before any decision is made.

Top module: `irq_prio_recog`

## Requirements
- R1: After reset `req_valid_o` is 0 and `req_level_o` and `new_mask_o` are 0.
- R2: A line of level n, for n from 1 to 6 (bit n-1 of `irq_n_i`), that is held low raises a request at level n only if n is greater than `mask_i`. If n is at or below the mask, no request is made.
- R3: When several eligible levels are pending, the highest-numbered one is presented.
- R4: Once valid, the level is held unchanged until a cycle with `take_i` high, whatever the lines do. That cycle clears the valid flag and the level. A `take_i` pulse while nothing is valid has no effect.
- R5: `new_mask_o` equals the presented level, so accepting level n loads n into the mask.
- R6: A level 1 to 6 line that stays low through its service is presented again in the cycle after the mask is lowered below it.
- R7: A falling edge on line 7 (bit 6 of `irq_n_i`) raises a level 7 request even when `mask_i` is 7.
- R8: After a level 7 request is taken, a line 7 that simply stays low raises no further request.
- R9: If line 7 rises and then falls again, even while level 7 is being serviced, a new level 7 request is raised. A rise alone raises none.
- R10: A pulse on `sr_wr_i` while line 7 is still low raises a new level 7 request with no pin transition. The same pulse while line 7 is high raises none.
- R11: Inputs pass two synchronizer flops. A level 1 to 6 request becomes valid at the third rising edge after the line falls, and a level 7 request at the fourth edge. Neither is valid earlier.
- R12: A level 7 falling edge is remembered until taken, even if the line returns high before the core accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n_i | input | 7 | Active-low request lines; bit n-1 carries level n |
| mask_i | input | 3 | Current interrupt mask from the status register |
| sr_wr_i | input | 1 | Status-register write strobe, including the restore on return |
| take_i | input | 1 | Core accepts the presented request |
| req_valid_o | output | 1 | A request is being presented |
| req_level_o | output | 3 | Encoded level of the presented request |
| new_mask_o | output | 3 | Mask value to load on acceptance |

## Verification
The hardest case is a level 7 request that comes back with no edge on the pin. To reach it, the stimulus accepts a level 7 request and keeps the line low long enough to show that nothing repeats. It then pulses the status-register write strobe alone and looks for the new request. The same write is then repeated with the line high, where no request may appear. A sweep over every combination of lines 1 to 6 and every mask value covers both the masking and the priority choice. A short low pulse on line 7 that ends before acceptance shows that the edge is remembered until the core takes it.

// File: rtl/irq_prio_pkg.sv
// Shared constants and types for the interrupt recognition unit.
// Assumes a fixed architecture of seven request levels with a 3-bit mask.
package irq_prio_pkg;
    localparam int unsigned IRQ_LEVELS = 7;
    localparam int unsigned IRQ_LVL_W  = $clog2(IRQ_LEVELS + 1);
    typedef logic [IRQ_LVL_W-1:0] irq_lvl_t;
endpackage

// File: rtl/irq_sync_bank.sv
// Multi-stage synchronizer bank for asynchronous active-low lines.
// Each bit gets its own shift chain and resets to the inactive (high) value.
// Assumes STAGES >= 2.
module irq_sync_bank #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_n,
    output logic [WIDTH-1:0] dout_n
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw line through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din_n[b]};
        end

        assign dout_n[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/irq_nmi_latch.sv
// Recognition logic for the non-maskable level.
// A recognition latch arms when the line falls, or when it is low while the
// latch is clear. The latch clears on a rising edge or on a status-register
// write; a set in the same cycle wins. Each arming raises a pending request,
// which stays until the core takes level 7.
// Assumes line_n is already synchronized.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    input  logic sr_wr,
    input  logic take_nmi,
    output logic pend
);
    logic prev_n;
    logic armed;
    logic fall;
    logic rise;
    logic arm_evt;

    assign fall    = prev_n & ~line_n;
    assign rise    = ~prev_n & line_n;
    assign arm_evt = ~armed & (fall | ~line_n);

    // Remember the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= line_n;
    end

    // Recognition latch: set wins over rise or write clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 1'b0;
        else if (arm_evt)        armed <= 1'b1;
        else if (rise || sr_wr)  armed <= 1'b0;
    end

    // Pending request held until the core takes level 7.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (arm_evt)  pend <= 1'b1;
        else if (take_nmi) pend <= 1'b0;
    end

    // R9: a falling edge always arms the latch.
    p_fall_arms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> armed);

    // R10: a write with no set event disarms the latch.
    p_write_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && armed && !fall) |=> !armed);

    // R12: pending stays until taken.
    p_pend_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take_nmi) |=> pend);
endmodule

// File: rtl/irq_prio_select.sv
// Mask comparison, priority choice and presented-level hold register.
// Levels 1..N-1 are active-high level inputs gated by the mask; the top
// level comes from the non-maskable pending flag. The chosen level is
// captured when nothing is presented and held until take.
module irq_prio_select
    import irq_prio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQ_LEVELS-2:0] lvl_act,
    input  logic                  nmi_pend,
    input  irq_lvl_t              mask,
    input  logic                  take,
    output logic                  valid,
    output irq_lvl_t              level
);
    logic [IRQ_LEVELS:1] cand;
    irq_lvl_t            best;

    // Build the eligible candidate vector from lines and mask.
    always_comb begin
        for (int i = 1; i < IRQ_LEVELS; i++) begin
            cand[i] = lvl_act[i-1] && (irq_lvl_t'(i) > mask);
        end
        cand[IRQ_LEVELS] = nmi_pend;
    end

    // Pick the highest-numbered eligible candidate.
    always_comb begin
        best = '0;
        for (int i = 1; i <= IRQ_LEVELS; i++) begin
            if (cand[i]) best = irq_lvl_t'(i);
        end
    end

    // Present a request and hold it until the core takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            level <= '0;
        end else if (valid && take) begin
            valid <= 1'b0;
            level <= '0;
        end else if (!valid && (|cand)) begin
            valid <= 1'b1;
            level <= best;
        end
    end

    // R4: a presented request is held until take.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take) |=> (valid && $stable(level)));

    // R4: take clears the presented request.
    p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && take) |=> !valid);

    // R2: a presented level is never zero.
    p_level_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (level != '0));
endmodule

// File: rtl/irq_prio_recog.sv
// Prioritized interrupt recognition unit (top).
// Synchronizes the request lines, recognizes the non-maskable level,
// compares the others with the mask and presents the winning level with
// the mask value to be loaded on acceptance.
module irq_prio_recog
    import irq_prio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQ_LEVELS-1:0] irq_n_i,
    input  logic [IRQ_LVL_W-1:0]  mask_i,
    input  logic                  sr_wr_i,
    input  logic                  take_i,
    output logic                  req_valid_o,
    output logic [IRQ_LVL_W-1:0]  req_level_o,
    output logic [IRQ_LVL_W-1:0]  new_mask_o
);
    localparam irq_lvl_t TOP_LVL = irq_lvl_t'(IRQ_LEVELS);

    logic [IRQ_LEVELS-1:0] sync_n;
    logic                  nmi_pend;
    logic                  take_nmi;

    irq_sync_bank #(
        .WIDTH  (IRQ_LEVELS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (irq_n_i),
        .dout_n (sync_n)
    );

    assign take_nmi = req_valid_o && take_i && (req_level_o == TOP_LVL);

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (sync_n[IRQ_LEVELS-1]),
        .sr_wr    (sr_wr_i),
        .take_nmi (take_nmi),
        .pend     (nmi_pend)
    );

    irq_prio_select u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_act  (~sync_n[IRQ_LEVELS-2:0]),
        .nmi_pend (nmi_pend),
        .mask     (mask_i),
        .take     (take_i),
        .valid    (req_valid_o),
        .level    (req_level_o)
    );

    assign new_mask_o = req_level_o;

    // R2: a newly presented maskable level beat the mask in force.
    p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid_o) && req_level_o != TOP_LVL) |-> (req_level_o > $past(mask_i)));

    // R5: the mask to load tracks the presented level.
    p_newmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (new_mask_o == req_level_o));
endmodule

// File: tb/irq_prio_recog_bench.sv
// Self-checking bench for the prioritized interrupt recognition unit.
module irq_prio_recog_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] irq_n = 7'h7F;
    logic [2:0] mask = 3'd0;
    logic       sr_wr = 1'b0;
    logic       take = 1'b0;
    logic       valid;
    logic [2:0] level;
    logic [2:0] new_mask;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_recog u_irq_prio_recog (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_n_i     (irq_n),
        .mask_i      (mask),
        .sr_wr_i     (sr_wr),
        .take_i      (take),
        .req_valid_o (valid),
        .req_level_o (level),
        .new_mask_o  (new_mask)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic v_exp, input logic [2:0] l_exp);
        logic [2:0] le;
        le = v_exp ? l_exp : 3'd0;
        checks++;
        if (valid !== v_exp || level !== le || new_mask !== le) begin
            fails++;
            $display("FAIL %s: valid=%0b level=%0d new_mask=%0d expected valid=%0b level=%0d",
                     tag, valid, level, new_mask, v_exp, le);
        end
    endtask

    // Take the presented request and load its level as the mask.
    task automatic accept(input logic [2:0] lvl);
        take = 1'b1;
        mask = lvl;
        tick(1);
        take = 1'b0;
    endtask

    // Take any request, release all lines and return to an idle state.
    task automatic retire();
        take = 1'b1;
        mask = 3'd7;
        tick(1);
        take = 1'b0;
        irq_n = 7'h7F;
        tick(5);
        mask = 3'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1", 1'b0, 3'd0);

        // R11: level 3 latency through the synchronizer.
        irq_n[2] = 1'b0;
        tick(2);
        chk("R11", 1'b0, 3'd0);
        tick(1);
        chk("R11", 1'b1, 3'd3);
        retire();

        // R2 and R3: every line pattern against every mask.
        for (int pat = 1; pat < 64; pat++) begin
            for (int m = 0; m < 8; m++) begin
                int e;
                mask = 3'(m);
                irq_n = {1'b1, ~pat[5:0]};
                tick(4);
                e = 0;
                for (int b = 0; b < 6; b++) begin
                    if (pat[b] && (b + 1) > m) e = b + 1;
                end
                if ($countones(pat[5:0]) == 1) chk("R2", e != 0, 3'(e));
                else                            chk("R3", e != 0, 3'(e));
                take = (e != 0);
                mask = 3'd7;
                tick(1);
                take = 1'b0;
                irq_n = 7'h7F;
                tick(4);
            end
        end
        mask = 3'd0;

        // R4 and R5: hold while lines change, then take.
        irq_n[1] = 1'b0;
        tick(4);
        chk("R4", 1'b1, 3'd2);
        irq_n[4] = 1'b0;
        irq_n[1] = 1'b1;
        tick(5);
        chk("R4", 1'b1, 3'd2);
        chk("R5", 1'b1, 3'd2);
        take = 1'b1;
        mask = 3'd2;
        tick(1);
        take = 1'b0;
        chk("R4", 1'b0, 3'd0);
        tick(1);
        chk("R5", 1'b1, 3'd5);
        retire();

        // R4: take while idle has no effect.
        take = 1'b1;
        tick(1);
        take = 1'b0;
        chk("R4", 1'b0, 3'd0);
        irq_n[0] = 1'b0;
        tick(4);
        chk("R4", 1'b1, 3'd1);
        retire();

        // R6: a still-low line returns once the mask drops.
        irq_n[3] = 1'b0;
        tick(4);
        chk("R6", 1'b1, 3'd4);
        accept(3'd4);
        tick(5);
        chk("R6", 1'b0, 3'd0);
        mask = 3'd0;
        tick(1);
        chk("R6", 1'b1, 3'd4);
        retire();

        // R7 and R11: level 7 ignores a full mask.
        mask = 3'd7;
        irq_n[6] = 1'b0;
        tick(3);
        chk("R11", 1'b0, 3'd0);
        tick(1);
        chk("R7", 1'b1, 3'd7);
        accept(3'd7);

        // R8: held low without a write, nothing repeats.
        tick(10);
        chk("R8", 1'b0, 3'd0);

        // R10: a status write while low re-fires.
        sr_wr = 1'b1;
        tick(1);
        sr_wr = 1'b0;
        tick(3);
        chk("R10", 1'b1, 3'd7);
        accept(3'd7);
        tick(5);
        chk("R8", 1'b0, 3'd0);

        // R9: rise alone is silent, a following fall re-fires.
        irq_n[6] = 1'b1;
        tick(4);
        chk("R9", 1'b0, 3'd0);
        irq_n[6] = 1'b0;
        tick(5);
        chk("R9", 1'b1, 3'd7);
        accept(3'd7);

        // R12: a short pulse is remembered after the line returns high.
        irq_n[6] = 1'b1;
        tick(4);
        irq_n[6] = 1'b0;
        tick(3);
        irq_n[6] = 1'b1;
        tick(5);
        chk("R12", 1'b1, 3'd7);
        accept(3'd7);
        tick(5);
        chk("R12", 1'b0, 3'd0);

        // R10: a status write while the line is high is silent.
        sr_wr = 1'b1;
        tick(1);
        sr_wr = 1'b0;
        tick(5);
        chk("R10", 1'b0, 3'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule